// File: doc/BRIEF.md
# Receive/Transmit FIFO Watermark and Automatic RTS Controller

This block sits beside a UART's receive and transmit FIFOs and turns their fill levels into three control signals. It raises a receive-ready flag when enough characters are waiting, and a transmit-space flag when enough room is free. The third signal is an active-low RTS line. When automatic flow control is enabled, RTS is released (driven high) when the receive FIFO gets too full. It is asserted again (driven low) once the FIFO has drained past a lower mark.

Each direction's threshold comes from a 2-bit coarse code. A per-direction override nibble replaces the code whenever the nibble is non-zero. The RTS halt and resume marks come from two nibbles in units of four characters. The block uses the programmed marks as given and does not check that they are consistent. The selected thresholds are also output, so that interrupt or status logic can report them.

The triggers and thresholds are combinational in the inputs. RTS is a registered output with hysteresis.

Top module: `fifo_watermark_ctl`

## Requirements
- R1: When `trig_ovr[7:4]` is zero, `rx_thresh` follows `rx_code`: 0→8, 1→16, 2→56, 3→60.
- R2: When `trig_ovr[3:0]` is zero, `tx_thresh` follows `tx_code`: 0→8, 1→16, 2→32, 3→56.
- R3: A non-zero nibble overrides the code for its direction, and the threshold becomes nibble×4. `trig_ovr[7:4]` is the receive nibble and `trig_ovr[3:0]` is the transmit nibble.
- R4: `rx_trig` is 1 exactly when `rx_level >= rx_thresh`, in the same cycle.
- R5: `tx_trig` is 1 exactly when `64 - tx_level >= tx_thresh`, in the same cycle.
- R6: With `auto_rts_en`=1, a clock edge seen with `rx_level >= 4*rts_marks[3:0]` sets `rts_n` to 1 after that edge.
- R7: With `auto_rts_en`=1 and `rx_level` below the halt mark, `rts_n` goes to 0 after an edge where `rx_level <= 4*rts_marks[7:4]`. Between the two marks, `rts_n` holds its value.
- R8: When both the halt and resume conditions are true at once (marks programmed with halt ≤ resume), halt wins and `rts_n` is 1.
- R9: With `auto_rts_en`=0, `rts_n` is 0 after the next edge and stays 0 whatever the receive level is.
- R10: During and after reset, `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Characters held in the receive FIFO (0..64) |
| tx_level | input | 7 | Characters held in the transmit FIFO (0..64) |
| rx_code | input | 2 | Coarse receive trigger code |
| tx_code | input | 2 | Coarse transmit trigger code |
| trig_ovr | input | 8 | Override nibbles: [7:4] receive, [3:0] transmit, each ×4 |
| rts_marks | input | 8 | RTS marks: [3:0] halt, [7:4] resume, each ×4 |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| rx_thresh | output | 7 | Selected receive threshold |
| tx_thresh | output | 7 | Selected transmit threshold |
| rx_trig | output | 1 | Receive level at or above its threshold |
| tx_trig | output | 1 | Free transmit space at or above its threshold |
| rts_n | output | 1 | Active-low RTS |

## Verification
Two things can happen on the same edge: the halt decision and the resume decision. This occurs when the marks are programmed with halt at or below resume, so a single receive level satisfies both. The bench provokes it by sweeping the receive level up and down through such a pair of marks, and through a halt mark of zero. At every clock it compares RTS with a behavioural model in which halt takes precedence. The triggers are compared on the same clocks while RTS is changing, so a change on the RTS path that disturbs the trigger outputs is caught.

// File: rtl/fifo_watermark_ctl.sv
module fifo_watermark_ctl #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [1:0]    rx_code,
  input  logic [1:0]    tx_code,
  input  logic [7:0]    trig_ovr,
  input  logic [7:0]    rts_marks,
  input  logic          auto_rts_en,
  output logic [LW-1:0] rx_thresh,
  output logic [LW-1:0] tx_thresh,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic          rts_n
);

  logic [LW-1:0] rx_coarse, tx_coarse, tx_space, halt_lvl, resume_lvl;
  logic [3:0]    rx_nib, tx_nib;

  assign rx_nib = trig_ovr[7:4];
  assign tx_nib = trig_ovr[3:0];

  always_comb begin
    case (rx_code)
      2'd0:    rx_coarse = LW'(8);
      2'd1:    rx_coarse = LW'(16);
      2'd2:    rx_coarse = LW'(56);
      default: rx_coarse = LW'(60);
    endcase
    case (tx_code)
      2'd0:    tx_coarse = LW'(8);
      2'd1:    tx_coarse = LW'(16);
      2'd2:    tx_coarse = LW'(32);
      default: tx_coarse = LW'(56);
    endcase
  end

  assign rx_thresh  = (rx_nib != 4'd0) ? (LW'(rx_nib) << 2) : rx_coarse;
  assign tx_thresh  = (tx_nib != 4'd0) ? (LW'(tx_nib) << 2) : tx_coarse;
  assign tx_space   = LW'(DEPTH) - tx_level;
  assign rx_trig    = rx_level >= rx_thresh;
  assign tx_trig    = tx_space >= tx_thresh;

  assign halt_lvl   = LW'(rts_marks[3:0]) << 2;
  assign resume_lvl = LW'(rts_marks[7:4]) << 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rts_n <= 1'b0;
    else if (!auto_rts_en)        rts_n <= 1'b0;
    else if (rx_level >= halt_lvl)   rts_n <= 1'b1;
    else if (rx_level <= resume_lvl) rts_n <= 1'b0;
  end

endmodule

// File: rtl/fifo_watermark_chk.sv
module fifo_watermark_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] rx_level,
  input logic [6:0] tx_level,
  input logic [7:0] rts_marks,
  input logic       auto_rts_en,
  input logic [6:0] rx_thresh,
  input logic [6:0] tx_thresh,
  input logic       rx_trig,
  input logic       tx_trig,
  input logic       rts_n
);
  logic [6:0] hl, rl;
  assign hl = {1'b0, rts_marks[3:0], 2'b00};
  assign rl = {1'b0, rts_marks[7:4], 2'b00};

  assert_rx_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig == (rx_level >= rx_thresh));
  assert_tx_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig == ((7'd64 - tx_level) >= tx_thresh));
  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= hl) |=> rts_n);
  assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level < hl && rx_level <= rl) |=> !rts_n);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level < hl && rx_level > rl) |=> $stable(rts_n));
  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> !rts_n);
  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |-> !rts_n);
endmodule

bind fifo_watermark_ctl fifo_watermark_chk u_chk (.*);

// File: tb/tb_fifo_watermark_ctl.sv
`timescale 1ns/1ps
module tb_fifo_watermark_ctl;
  logic clk = 0, rst_n = 0;
  logic [6:0] rx_level = 0, tx_level = 0;
  logic [1:0] rx_code = 0, tx_code = 0;
  logic [7:0] trig_ovr = 0, rts_marks = 0;
  logic auto_rts_en = 0;
  logic [6:0] rx_thresh, tx_thresh;
  logic rx_trig, tx_trig, rts_n;
  int compared = 0, mismatched = 0;
  bit done = 0;
  int exp_halted = 0;

  always #2.5 clk = ~clk;

  fifo_watermark_ctl dut (.*);

  function automatic int rx_ref();
    int tbl[4] = '{8, 16, 56, 60};
    return (trig_ovr[7:4] != 0) ? trig_ovr[7:4] * 4 : tbl[rx_code];
  endfunction
  function automatic int tx_ref();
    int tbl[4] = '{8, 16, 32, 56};
    return (trig_ovr[3:0] != 0) ? trig_ovr[3:0] * 4 : tbl[tx_code];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_halted <= 0;
    else if (!auto_rts_en) exp_halted <= 0;
    else if (rx_level >= rts_marks[3:0] * 4) exp_halted <= 1;
    else if (rx_level <= rts_marks[7:4] * 4) exp_halted <= 0;
  end

  task automatic cmp(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    if (!rst_n) cmp("R10 rts_n in reset", rts_n, 0);
    else begin
      cmp("R1 R3 rx_thresh", rx_thresh, rx_ref());
      cmp("R2 R3 tx_thresh", tx_thresh, tx_ref());
      cmp("R4 rx_trig", rx_trig, int'(rx_level) >= rx_ref());
      cmp("R5 tx_trig", tx_trig, (64 - int'(tx_level)) >= tx_ref());
      cmp("R6 R7 R8 R9 rts_n", rts_n, exp_halted);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 R2: coarse codes across levels
    for (int c = 0; c < 4; c++) begin
      rx_code = 2'(c); tx_code = 2'(3 - c);
      for (int l = 0; l <= 64; l++) begin
        rx_level = 7'(l); tx_level = 7'(64 - l); step(1);
      end
    end
    // R3: override nibbles, mixed with zero nibbles
    for (int n = 0; n < 16; n++) begin
      trig_ovr = {4'(n), 4'(15 - n)};
      for (int l = 0; l <= 64; l += 3) begin
        rx_level = 7'(l); tx_level = 7'(l); step(1);
      end
    end
    trig_ovr = 0;
    // R6 R7: normal hysteresis halt=32 resume=8
    rts_marks = 8'h28; auto_rts_en = 1;
    for (int l = 0; l <= 40; l++) begin rx_level = 7'(l); step(1); end
    for (int l = 40; l >= 0; l--) begin rx_level = 7'(l); step(1); end
    for (int l = 0; l <= 20; l++) begin rx_level = 7'(l); step(1); end
    // R9: disable while level is high
    rx_level = 50; step(2);
    auto_rts_en = 0;
    for (int l = 64; l >= 0; l -= 4) begin rx_level = 7'(l); step(1); end
    // R8: misprogrammed marks halt=8 resume=32, and halt=0
    auto_rts_en = 1; rts_marks = 8'h82;
    for (int l = 0; l <= 40; l++) begin rx_level = 7'(l); step(1); end
    for (int l = 40; l >= 0; l--) begin rx_level = 7'(l); step(1); end
    rts_marks = 8'h30;
    for (int l = 0; l <= 16; l++) begin rx_level = 7'(l); step(1); end
    // R10: reset in the halted state
    rts_marks = 8'h28; rx_level = 60; step(2);
    rst_n = 0; step(2); rst_n = 1; rx_level = 10; step(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule